// File: doc/BRIEF.md
# Nibble-Polarity Event Sense Interrupt Unit

This unit watches 32 already-synchronized input lines for edges and latches one event flag per line. Which edge counts is chosen once for every group of four neighbouring lines: the rising edge (low-to-high) or the falling edge (high-to-low). Each line can be switched on or off for sensing on its own. A line that has latched stays latched until software clears it. Software sees the flags through four byte-wide port registers and a summary byte. An interrupt request output is raised while any flag is latched, provided the interrupt enable bit is set.

Every line runs a small state machine with four states. In `CH_IDLE` sensing is off. In `CH_ARMED` it is waiting for an edge. In `CH_LATCHED` an event has been captured. In `CH_HELD` sensing is off, but an edge that arrived during the clearing write is being kept. The transitions are as follows:
- `CH_IDLE` moves to `CH_ARMED` on a write of 1.
- `CH_ARMED` moves to `CH_LATCHED` on a qualifying edge.
- `CH_ARMED` and `CH_LATCHED` both move to `CH_IDLE` on a write of 0. If an edge arrives in that same cycle, they move to `CH_HELD` instead.
- `CH_HELD` moves to `CH_LATCHED` on a write of 1, and to `CH_IDLE` on a write of 0.

The software reset is a single-cycle internal pulse. It is requested through the interrupt enable register. It returns every line to `CH_IDLE` and clears the polarity byte. The enable and vector registers are left untouched.

Register map (8-bit data, 3-bit address): 0 to 3 are the port event registers, 4 is the polarity byte, 5 is the summary byte, 6 is the interrupt enable register and 7 is the vector register. Reads are combinational. Writes take effect at the clock edge on which `wr_en` is high.

Top module: `evt_sense_irq`

## Requirements
- R1: A line in `CH_ARMED` latches an event on the first clock edge at which its input differs from the value it had one cycle earlier in the direction its nibble selects. A rise is 0 to 1, and a fall is 1 to 0.
- R2: Bit n of the polarity register (address 4) controls lines 4n to 4n+3. A value of 0 selects rising edges and 1 selects falling edges. An edge of the other direction latches nothing.
- R3: Reading port register p (addresses 0 to 3) returns the latched flags of lines 8p to 8p+7, with bit b standing for line 8p+b. Writing 0 to bit b clears that line's flag and turns its sensing off. Writing 1 arms a line whose sensing is off. Writing 1 leaves an armed line armed and a latched line latched.
- R4: A line whose sensing is off latches nothing, whatever its input does.
- R5: The summary register (address 5) has four port bits and one global bit. Bit p is set when any line of port p is latched. Bit 7 is set when any line at all is latched. Bits 4 to 6 read 0.
- R6: `irq` is high exactly when bit 0 of the enable register (address 6) is 1 and at least one line is latched.
- R7: An edge of the selected direction may arrive in the same cycle as a 0-write to its line. In that case the line reads 0 and is latched by the next 1-write to its bit. A second 0-write discards the held edge.
- R8: After `rst_n` is released, all flags and the polarity, enable and vector registers read 0, every line's sensing is off, and `irq` is low.
- R9: Writing 1 to bit 1 of the enable register starts a one-cycle software reset. In the cycle after the write, all lines return to sensing-off and unlatched, and the polarity register clears. The enable bit 0 and the vector register keep their values. Bit 1 always reads 0.
- R10: The vector register (address 7) holds the last byte written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| din | input | 32 | Synchronized input lines |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the edge that arrives in the same cycle as a clearing write. A design that drops it would read 0 after re-arming, and one that latches it at once would flag an event while sensing is off. It drives edges of the wrong direction on a nibble set to falling, and edges on lines that are disarmed or freshly cleared. A design with polarity or enable errors would flag these. The software reset is checked for wiping the lines and polarity while keeping the vector and enable bit. A reset that clears too much, or too little, shows up in those reads. The interrupt line is checked with the enable bit both off and on, against a live latched flag.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int REG_W = 8;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_POL = 3'd4;
    localparam logic [ADDR_W-1:0] A_SUM = 3'd5;
    localparam logic [ADDR_W-1:0] A_IEN = 3'd6;
    localparam logic [ADDR_W-1:0] A_VEC = 3'd7;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_ARMED   = 2'd1,
        CH_LATCHED = 2'd2,
        CH_HELD    = 2'd3
    } ch_state_t;
endpackage

// File: rtl/evt_chan.sv
module evt_chan
    import evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic din,
    input  logic pol_fall,
    input  logic wr_hit,
    input  logic wr_bit,
    output logic latched,
    output logic armed,
    output logic held
);
    ch_state_t state_q, state_d;
    logic      prev_q;
    logic      edge_seen;

    assign edge_seen = pol_fall ? (prev_q & ~din) : (~prev_q & din);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            prev_q  <= 1'b0;
        end else begin
            prev_q <= din;
            if (srst) state_q <= CH_IDLE;
            else      state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (wr_hit && wr_bit) state_d = CH_ARMED;
            end
            CH_ARMED: begin
                if (wr_hit && !wr_bit) state_d = edge_seen ? CH_HELD : CH_IDLE;
                else if (edge_seen)    state_d = CH_LATCHED;
            end
            CH_LATCHED: begin
                if (wr_hit && !wr_bit) state_d = edge_seen ? CH_HELD : CH_IDLE;
            end
            CH_HELD: begin
                if (wr_hit) state_d = wr_bit ? CH_LATCHED : CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        latched = (state_q == CH_LATCHED);
        armed   = (state_q == CH_ARMED);
        held    = (state_q == CH_HELD);
    end
endmodule

// File: rtl/evt_regs.sv
module evt_regs
    import evt_pkg::*;
#(
    parameter int NIBBLES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REG_W-1:0]   wdata,
    output logic [NIBBLES-1:0] pol_q,
    output logic               ien_q,
    output logic [REG_W-1:0]   vec_q,
    output logic               srst_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q  <= '0;
            ien_q  <= 1'b0;
            vec_q  <= '0;
            srst_q <= 1'b0;
        end else begin
            srst_q <= wr_en && (addr == A_IEN) && wdata[1];
            if (wr_en && addr == A_IEN) ien_q <= wdata[0];
            if (wr_en && addr == A_VEC) vec_q <= wdata;
            if (srst_q)                      pol_q <= '0;
            else if (wr_en && addr == A_POL) pol_q <= wdata[NIBBLES-1:0];
        end
    end
endmodule

// File: rtl/evt_sense_irq.sv
module evt_sense_irq
    import evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [31:0]       din,
    output logic              irq
);
    localparam int PORTS   = 4;
    localparam int LINES   = PORTS * REG_W;
    localparam int NIB_W   = 4;
    localparam int NIBBLES = LINES / NIB_W;

    logic [NIBBLES-1:0] pol_q;
    logic               ien_q;
    logic [REG_W-1:0]   vec_q;
    logic               srst_q;
    logic [LINES-1:0]   lat_vec, arm_vec, held_vec;
    logic [REG_W-1:0]   summary;

    evt_regs #(.NIBBLES(NIBBLES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .pol_q(pol_q), .ien_q(ien_q), .vec_q(vec_q), .srst_q(srst_q)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic hit;
        assign hit = wr_en && !srst_q && (addr == ADDR_W'(i / REG_W));
        evt_chan u_chan (
            .clk(clk), .rst_n(rst_n), .srst(srst_q), .din(din[i]),
            .pol_fall(pol_q[i / NIB_W]), .wr_hit(hit), .wr_bit(wdata[i % REG_W]),
            .latched(lat_vec[i]), .armed(arm_vec[i]), .held(held_vec[i])
        );
    end

    always_comb begin
        summary = '0;
        for (int p = 0; p < PORTS; p++)
            summary[p] = |lat_vec[p*REG_W +: REG_W];
        summary[REG_W-1] = |lat_vec;
    end

    assign irq = ien_q & summary[REG_W-1];

    always_comb begin
        unique case (addr)
            3'd0, 3'd1, 3'd2, 3'd3: rdata = lat_vec[addr[1:0]*REG_W +: REG_W];
            A_POL:   rdata = pol_q;
            A_SUM:   rdata = summary;
            A_IEN:   rdata = {7'b0, ien_q};
            A_VEC:   rdata = vec_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/evt_sense_irq_chk.sv
module evt_sense_irq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [2:0]  addr,
    input logic [7:0]  wdata,
    input logic        irq,
    input logic        ien_q,
    input logic        srst_q,
    input logic [7:0]  vec_q,
    input logic [7:0]  summary,
    input logic [31:0] lat_vec,
    input logic [31:0] arm_vec,
    input logic [31:0] held_vec
);
    // R6: request only with enable and a pending event
    a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien_q && summary[7]));

    // R1: a flag can only appear on a line that was armed or holding an edge
    a_r1_latch_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        ((lat_vec & ~$past(lat_vec) & ~($past(arm_vec) | $past(held_vec))) == 32'h0));

    // R3: clearing write to port 0 leaves no flag there
    a_r3_clear_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !srst_q && addr == 3'd0 && wdata == 8'h00) |=> (lat_vec[7:0] == 8'h00));

    // R9: reset pulse lasts one cycle
    a_r9_srst_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> !srst_q);

    // R9: reset pulse clears every line
    a_r9_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> (lat_vec == 32'h0 && arm_vec == 32'h0 && held_vec == 32'h0));

    // R9: reset pulse keeps vector and enable
    a_r9_srst_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_q && !wr_en) |=> ($stable(vec_q) && $stable(ien_q)));
endmodule

bind evt_sense_irq evt_sense_irq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .irq(irq), .ien_q(ien_q), .srst_q(srst_q), .vec_q(vec_q),
    .summary(summary), .lat_vec(lat_vec), .arm_vec(arm_vec), .held_vec(held_vec)
);

// File: tb/evt_sense_irq_bench.sv
`timescale 1ns/1ps
module evt_sense_irq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [31:0] din = '0;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        int        what;   // 0..7 register, 8 = irq pin
        logic [7:0] exp;
        string     req;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    evt_sense_irq u_evt_sense_irq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .din(din), .irq(irq)
    );

    // monitor
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            act = (it.what == 8) ? {7'b0, irq} : rdata;
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: sel %0d actual %h expected %h", it.req, it.what, act, it.exp);
            end
        end
    end

    task automatic expect_val(input int what, input logic [7:0] e, input string req);
        item_t it;
        @(negedge clk); #1;
        if (what < 8) addr = 3'(what);
        it.what = what; it.exp = e; it.req = req;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic drive(input logic [31:0] v);
        @(negedge clk); #1;
        din = v;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R8 reset state
        for (int r = 0; r < 8; r++) expect_val(r, 8'h00, "R8");
        expect_val(8, 8'h00, "R8");

        wr(3'd7, 8'hA5);
        expect_val(7, 8'hA5, "R10");
        wr(3'd6, 8'h01);
        expect_val(6, 8'h01, "R9 bit1 reads 0");

        // R1 rising edge on armed line 0
        wr(3'd0, 8'hFF);
        expect_val(0, 8'h00, "R3 armed not latched");
        drive(32'h0000_0001);
        expect_val(0, 8'h01, "R1");
        expect_val(5, 8'h81, "R5");
        expect_val(8, 8'h01, "R6");

        // R2 nibble 1 set to falling
        wr(3'd4, 8'h02);
        expect_val(4, 8'h02, "R2 readback");
        drive(32'h0000_0011);
        expect_val(0, 8'h01, "R2 rise ignored");
        drive(32'h0000_0001);
        expect_val(0, 8'h11, "R2 fall latched");

        // R4 disarmed port 1
        drive(32'h0000_0101);
        expect_val(1, 8'h00, "R4");
        expect_val(5, 8'h81, "R5 port1 clear");

        // R3 clear lines 0 and 4
        wr(3'd0, 8'hEE);
        expect_val(0, 8'h00, "R3 clear");
        expect_val(5, 8'h00, "R5 none");
        expect_val(8, 8'h00, "R6 no event");
        drive(32'h0000_0100);
        drive(32'h0000_0101);
        expect_val(0, 8'h00, "R4 cleared line off");
        wr(3'd0, 8'hFF);
        drive(32'h0000_0100);
        expect_val(0, 8'h00, "R1 wrong edge");
        drive(32'h0000_0101);
        expect_val(0, 8'h01, "R3 rearm");

        // R6 enable off
        wr(3'd6, 8'h00);
        expect_val(8, 8'h00, "R6 disabled");
        expect_val(5, 8'h81, "R5 polled");
        wr(3'd6, 8'h01);
        expect_val(8, 8'h01, "R6 enabled");

        // R7 edge coinciding with clear
        wr(3'd2, 8'hFF);
        @(negedge clk); #1;
        addr = 3'd2; wdata = 8'h00; wr_en = 1'b1; din = 32'h0001_0101;
        @(negedge clk); #1;
        wr_en = 1'b0;
        expect_val(2, 8'h00, "R7 held reads 0");
        wr(3'd2, 8'h01);
        expect_val(2, 8'h01, "R7 latched on rearm");
        expect_val(5, 8'h85, "R5 ports 0 and 2");
        wr(3'd2, 8'h00);
        wr(3'd2, 8'h01);
        expect_val(2, 8'h00, "R7 plain clear no event");

        // R9 software reset
        wr(3'd6, 8'h03);
        expect_val(6, 8'h01, "R9 enable kept");
        expect_val(7, 8'hA5, "R9 vector kept");
        expect_val(0, 8'h00, "R9 flags cleared");
        expect_val(4, 8'h00, "R9 polarity cleared");
        expect_val(5, 8'h00, "R9 summary");
        expect_val(8, 8'h00, "R9 irq low");
        drive(32'h0001_0100);
        drive(32'h0001_0101);
        expect_val(0, 8'h00, "R9 sensing off");

        // R5 port 3
        wr(3'd3, 8'h80);
        drive(32'h8001_0101);
        expect_val(3, 8'h80, "R1 line 31");
        expect_val(5, 8'h88, "R5 port3");
        expect_val(8, 8'h01, "R6 port3");

        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule